// File: doc/BRIEF.md
# SRAM Write Timing Monitor

This block watches the address, data and the two active-low strobes (chip select and write strobe) of an asynchronous static RAM bus. It samples them on a fast clock and checks every write against a set of minimum intervals. It drives nothing on the memory bus. A write window opens when the second of the two strobes goes low and closes when the first of them goes high. Every interval is measured as a whole number of samples. Each limit is given in nanoseconds and is converted to a sample count by rounding up.

Each timing rule has its own sticky violation bit. A bit stays set until a clear pulse. The number of the rule that broke first is held next to the bits. A 16-bit counter counts the write windows that have closed. Two of the rules, address recovery and data hold, offer two ways to pass. A rule is met if the signal stays stable long enough after the write strobe rises, or long enough after the chip select rises.

Top module: `sram_wmon`

## Requirements
- R1: After reset, `viol_flags` is zero, `first_vld` is low and `wr_count` is zero.
- R2: `wr_count` increases by one each time a window closes. A window needs both strobes low together, so a strobe that is low on its own is never counted.
- R3: Flag bit 4 sets when the window is open for fewer than ceil(T_WP_NS/SAMPLE_NS) samples.
- R4: Flag bit 1 sets when chip select falls fewer than ceil(T_CEW_NS/SAMPLE_NS) samples before the window closes. Flag bit 2 sets when the last address change is fewer than ceil(T_AVW_NS/SAMPLE_NS) samples before the window closes.
- R5: Flag bit 5 sets when the last data change is fewer than ceil(T_DW_NS/SAMPLE_NS) samples before the window closes.
- R6: Flag bit 0 sets when two address changes are fewer than ceil(T_CYC_NS/SAMPLE_NS) samples apart.
- R7: An address change after a window closes sets flag bit 6 unless one of two things holds: the write strobe has been high for at least ceil(T_WR_WE_NS/SAMPLE_NS) samples, or chip select has been high for at least ceil(T_WR_CE_NS/SAMPLE_NS) samples.
- R8: A data change after a window closes sets flag bit 7 unless one of two things holds: the write strobe has been high for at least ceil(T_DH_WE_NS/SAMPLE_NS) samples, or chip select has been high for at least ceil(T_DH_CE_NS/SAMPLE_NS) samples. With the default zero limit for the write strobe, data may change on the very sample where the write strobe rises.
- R9: An address or data change while the window is open sets flag bit 8.
- R10: Flag bits are sticky until `clr_flags` is pulsed. `first_code` holds the bit number of the first violation, and `first_vld` marks it as valid. If several rules fail on the same sample, the lowest bit number wins. A clear resets the flags and the first code but not `wr_count`.
- R11: Flag bit 3 sets when the address changes fewer than ceil(T_AS_NS/SAMPLE_NS) samples before the window opens. With the default limit of zero, an address change on the same sample as the window opens is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_flags | input | 1 | Clears the violation bits and the first-error record |
| mem_addr | input | ADDR_W | Observed address bus |
| mem_data | input | DATA_W | Observed data bus |
| mem_ce_n | input | 1 | Observed chip select, active low |
| mem_we_n | input | 1 | Observed write strobe, active low |
| viol_flags | output | 9 | Sticky violation bits, one per rule |
| first_vld | output | 1 | A violation has been recorded since the last clear |
| first_code | output | 4 | Bit number of the first violation |
| wr_count | output | 16 | Closed write windows, wrapping |

## Verification
Writes are driven in several ways. In some, both strobes fall and rise together. In others, chip select brackets a shorter write strobe pulse, or the write strobe brackets a shorter chip select pulse. This shows that the window follows the later fall and the earlier rise. Address and data changes are placed on the exact sample of a strobe edge, and one sample past it. This separates the two alternatives of the recovery and hold rules, and it shows that a change on the closing sample is not counted against the data-valid rule. Finally, two violations are raised in reverse priority order, to show that the first-error code records time order and not bit order.

// File: rtl/sram_wmon_pkg.sv
`timescale 1ns/1ps
package sram_wmon_pkg;

   // Rule numbers double as flag bit positions.
   typedef enum logic [3:0] {
      CHK_CYC = 4'd0,
      CHK_CEW = 4'd1,
      CHK_AVW = 4'd2,
      CHK_AS  = 4'd3,
      CHK_WP  = 4'd4,
      CHK_DW  = 4'd5,
      CHK_WR  = 4'd6,
      CHK_DH  = 4'd7,
      CHK_OVL = 4'd8
   } chk_e;

   localparam int NUM_CHK = 9;
   localparam int CODE_W  = 4;

   // Interval events timed by the block.
   localparam int EV_ADDR = 0;
   localparam int EV_DATA = 1;
   localparam int EV_CEF  = 2;
   localparam int EV_WS   = 3;
   localparam int EV_WER  = 4;
   localparam int EV_CER  = 5;
   localparam int NUM_EV  = 6;

   function automatic int ns2cnt(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction

endpackage

// File: rtl/sram_wmon_sampler.sv
`timescale 1ns/1ps
module sram_wmon_sampler #(
   parameter int          W       = 8,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sram_wmon_sampler: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur <= RST_VAL;
            else        cur <= din;
         end
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES-1; i++) pipe[i] <= RST_VAL;
               cur <= RST_VAL;
            end else begin
               pipe[0] <= din;
               for (int i = 1; i < STAGES-1; i++) pipe[i] <= pipe[i-1];
               cur <= pipe[STAGES-2];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= cur;
   end

endmodule

// File: rtl/sram_wmon_ivl.sv
`timescale 1ns/1ps
module sram_wmon_ivl #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt,
   output logic [CW-1:0] elapsed
);

   // Samples since the last event, saturating; starts saturated.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               elapsed <= '1;
      else if (evt)             elapsed <= CW'(1);
      else if (elapsed != '1)   elapsed <= elapsed + 1'b1;
   end

endmodule

// File: rtl/sram_wmon_sticky.sv
`timescale 1ns/1ps
module sram_wmon_sticky #(
   parameter int N      = 9,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [N-1:0]      hit,
   output logic [N-1:0]      flags,
   output logic              first_vld,
   output logic [CODE_W-1:0] first_code
);

   logic [CODE_W-1:0] hit_code;

   generate
      if ((1 << CODE_W) < N) begin : g_bad_code
         $error("sram_wmon_sticky: CODE_W too small for N");
      end
   endgenerate

   always_comb begin
      hit_code = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (hit[i]) hit_code = CODE_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags      <= '0;
         first_vld  <= 1'b0;
         first_code <= '0;
      end else if (clr) begin
         flags      <= '0;
         first_vld  <= 1'b0;
         first_code <= '0;
      end else begin
         flags <= flags | hit;
         if (!first_vld && (|hit)) begin
            first_vld  <= 1'b1;
            first_code <= hit_code;
         end
      end
   end

endmodule

// File: rtl/sram_wmon.sv
`timescale 1ns/1ps
module sram_wmon
   import sram_wmon_pkg::*;
#(
   parameter int ADDR_W      = 21,
   parameter int DATA_W      = 8,
   parameter int SAMPLE_NS   = 10,
   parameter int SYNC_STAGES = 2,
   parameter int CW          = 8,
   parameter int CNT_W       = 16,
   parameter int T_CYC_NS    = 70,
   parameter int T_CEW_NS    = 65,
   parameter int T_AVW_NS    = 65,
   parameter int T_AS_NS     = 0,
   parameter int T_WP_NS     = 55,
   parameter int T_DW_NS     = 30,
   parameter int T_WR_WE_NS  = 5,
   parameter int T_WR_CE_NS  = 15,
   parameter int T_DH_WE_NS  = 0,
   parameter int T_DH_CE_NS  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_flags,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              mem_ce_n,
   input  logic              mem_we_n,
   output logic [8:0]        viol_flags,
   output logic              first_vld,
   output logic [3:0]        first_code,
   output logic [15:0]       wr_count
);

   localparam int N_CYC   = ns2cnt(T_CYC_NS,   SAMPLE_NS);
   localparam int N_CEW   = ns2cnt(T_CEW_NS,   SAMPLE_NS);
   localparam int N_AVW   = ns2cnt(T_AVW_NS,   SAMPLE_NS);
   localparam int N_AS    = ns2cnt(T_AS_NS,    SAMPLE_NS);
   localparam int N_WP    = ns2cnt(T_WP_NS,    SAMPLE_NS);
   localparam int N_DW    = ns2cnt(T_DW_NS,    SAMPLE_NS);
   localparam int N_WR_WE = ns2cnt(T_WR_WE_NS, SAMPLE_NS);
   localparam int N_WR_CE = ns2cnt(T_WR_CE_NS, SAMPLE_NS);
   localparam int N_DH_WE = ns2cnt(T_DH_WE_NS, SAMPLE_NS);
   localparam int N_DH_CE = ns2cnt(T_DH_CE_NS, SAMPLE_NS);
   localparam int SAT     = (1 << CW) - 1;
   localparam int SMP_W   = ADDR_W + DATA_W + 2;
   localparam logic [SMP_W-1:0] SMP_RST = {{(ADDR_W+DATA_W){1'b0}}, 2'b11};

   // Elaboration-time parameter checks
   generate
      if (SAMPLE_NS < 1) begin : g_bad_period
         $error("sram_wmon: SAMPLE_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_wmon: bus widths must be positive");
      end
      if (CNT_W != 16) begin : g_bad_cnt
         $error("sram_wmon: wr_count port is 16 bits wide");
      end
      if (N_CYC >= SAT || N_CEW >= SAT || N_AVW >= SAT || N_AS >= SAT ||
          N_WP >= SAT || N_DW >= SAT || N_WR_WE >= SAT || N_WR_CE >= SAT ||
          N_DH_WE >= SAT || N_DH_CE >= SAT) begin : g_bad_cw
         $error("sram_wmon: a limit does not fit the interval counter width CW");
      end
   endgenerate

   function automatic logic at_least(input logic [CW-1:0] v, input int lim);
      return int'({1'b0, v}) >= lim;
   endfunction

   // Input sampling
   logic [SMP_W-1:0]  smp_cur, smp_prev;
   logic [ADDR_W-1:0] a_cur, a_prev;
   logic [DATA_W-1:0] d_cur, d_prev;
   logic              ce_cur, ce_prev, we_cur, we_prev;

   sram_wmon_sampler #(
      .W(SMP_W), .STAGES(SYNC_STAGES), .RST_VAL(SMP_RST)
   ) u_smp (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({mem_addr, mem_data, mem_ce_n, mem_we_n}),
      .cur  (smp_cur),
      .prev (smp_prev)
   );

   assign {a_cur,  d_cur,  ce_cur,  we_cur}  = smp_cur;
   assign {a_prev, d_prev, ce_prev, we_prev} = smp_prev;

   // Events on the current sample
   logic win_cur, win_prev, wr_start, wr_end;
   logic [NUM_EV-1:0] evt;

   assign win_cur  = !ce_cur  && !we_cur;
   assign win_prev = !ce_prev && !we_prev;
   assign wr_start = win_cur && !win_prev;
   assign wr_end   = !win_cur && win_prev;

   always_comb begin
      evt          = '0;
      evt[EV_ADDR] = (a_cur != a_prev);
      evt[EV_DATA] = (d_cur != d_prev);
      evt[EV_CEF]  = !ce_cur && ce_prev;
      evt[EV_WS]   = wr_start;
      evt[EV_WER]  = we_cur && !we_prev;
      evt[EV_CER]  = ce_cur && !ce_prev;
   end

   // One interval counter per event kind
   logic [CW-1:0] el [NUM_EV];

   generate
      for (genvar g = 0; g < NUM_EV; g++) begin : g_ivl
         sram_wmon_ivl #(.CW(CW)) u_ivl (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt[g]),
            .elapsed(el[g])
         );
      end
   endgenerate

   // Distance including an event on this very sample
   logic [CW-1:0] dist_addr, dist_wer, dist_cer;
   assign dist_addr = evt[EV_ADDR] ? '0 : el[EV_ADDR];
   assign dist_wer  = evt[EV_WER]  ? '0 : el[EV_WER];
   assign dist_cer  = evt[EV_CER]  ? '0 : el[EV_CER];

   // Post-window alternatives
   logic wr_we_ok, wr_ce_ok, dh_we_ok, dh_ce_ok;
   assign wr_we_ok = we_cur && at_least(dist_wer, N_WR_WE);
   assign wr_ce_ok = ce_cur && at_least(dist_cer, N_WR_CE);
   assign dh_we_ok = we_cur && at_least(dist_wer, N_DH_WE);
   assign dh_ce_ok = ce_cur && at_least(dist_cer, N_DH_CE);

   logic rec_pend, hold_pend, rec_act, hold_act, rec_ok, hold_ok;
   assign rec_act  = rec_pend  || wr_end;
   assign hold_act = hold_pend || wr_end;
   assign rec_ok   = wr_we_ok || wr_ce_ok;
   assign hold_ok  = dh_we_ok || dh_ce_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_pend  <= 1'b0;
         hold_pend <= 1'b0;
      end else begin
         if (wr_start)                              rec_pend <= 1'b0;
         else if (rec_act && (evt[EV_ADDR] || rec_ok)) rec_pend <= 1'b0;
         else if (wr_end)                           rec_pend <= 1'b1;

         if (wr_start)                               hold_pend <= 1'b0;
         else if (hold_act && (evt[EV_DATA] || hold_ok)) hold_pend <= 1'b0;
         else if (wr_end)                            hold_pend <= 1'b1;
      end
   end

   // Rule evaluation
   logic [NUM_CHK-1:0] hit;

   always_comb begin
      hit          = '0;
      hit[CHK_CYC] = evt[EV_ADDR] && !at_least(el[EV_ADDR], N_CYC);
      hit[CHK_AS]  = wr_start && !at_least(dist_addr, N_AS);
      hit[CHK_CEW] = wr_end && !at_least(el[EV_CEF],  N_CEW);
      hit[CHK_AVW] = wr_end && !at_least(el[EV_ADDR], N_AVW);
      hit[CHK_WP]  = wr_end && !at_least(el[EV_WS],   N_WP);
      hit[CHK_DW]  = wr_end && !at_least(el[EV_DATA], N_DW);
      hit[CHK_WR]  = rec_act  && evt[EV_ADDR] && !rec_ok;
      hit[CHK_DH]  = hold_act && evt[EV_DATA] && !hold_ok;
      hit[CHK_OVL] = win_cur && win_prev && (evt[EV_ADDR] || evt[EV_DATA]);
   end

   sram_wmon_sticky #(.N(NUM_CHK), .CODE_W(CODE_W)) u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_flags),
      .hit       (hit),
      .flags     (viol_flags),
      .first_vld (first_vld),
      .first_code(first_code)
   );

   // Completed window counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_count <= '0;
      else if (wr_end) wr_count <= wr_count + 16'd1;
   end

endmodule

// File: rtl/sram_wmon_chk.sv
`timescale 1ns/1ps
module sram_wmon_chk #(
   parameter int NUM    = 9,
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_flags,
   input logic [NUM-1:0]    viol_flags,
   input logic              first_vld,
   input logic [CODE_W-1:0] first_code,
   input logic [15:0]       wr_count
);

   logic [NUM-1:0] code_sel;
   assign code_sel = viol_flags >> first_code;

   // R10
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_flags |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

   // R10
   flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_flags |=> (viol_flags == '0 && !first_vld));

   // R10
   first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (first_vld && !clr_flags) |=> (first_vld && $stable(first_code)));

   // R10
   first_points_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first_vld |-> code_sel[0]);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_count != $past(wr_count)) |-> (wr_count == $past(wr_count) + 16'd1));

endmodule

bind sram_wmon sram_wmon_chk #(.NUM(9), .CODE_W(4)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_flags (clr_flags),
   .viol_flags(viol_flags),
   .first_vld (first_vld),
   .first_code(first_code),
   .wr_count  (wr_count)
);

// File: tb/sram_wmon_tb.sv
`timescale 1ns/1ps
module sram_wmon_tb;

   localparam int AW = 21;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_flags = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_data = '0;
   logic          mem_ce_n = 1'b1;
   logic          mem_we_n = 1'b1;
   logic [8:0]    viol_flags;
   logic          first_vld;
   logic [3:0]    first_code;
   logic [15:0]   wr_count;

   always #5 clk = ~clk;

   sram_wmon u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_flags (clr_flags),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_ce_n  (mem_ce_n),
      .mem_we_n  (mem_we_n),
      .viol_flags(viol_flags),
      .first_vld (first_vld),
      .first_code(first_code),
      .wr_count  (wr_count)
   );

   typedef struct {
      string       tag;
      logic [8:0]  flags;
      logic        vld;
      logic [3:0]  code;
      logic [15:0] cnt;
   } exp_t;

   exp_t q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 0;
   int   cnt_exp = 0;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_state(input string tag, input logic [8:0] fl,
                               input logic vld, input logic [3:0] code);
      exp_t e;
      tick(6);
      e.tag = tag; e.flags = fl; e.vld = vld; e.code = code;
      e.cnt = 16'(cnt_exp);
      q.push_back(e);
      tick(1);
   endtask

   task automatic clear_flags();
      clr_flags = 1'b1;
      tick(1);
      clr_flags = 1'b0;
      tick(3);
   endtask

   // Monitor: compare queued expectations away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (viol_flags !== e.flags || first_vld !== e.vld ||
                (e.vld && first_code !== e.code) || wr_count !== e.cnt) begin
               n_fail++;
               $display("FAIL %s: flags=%h vld=%b code=%0d cnt=%0d, expected flags=%h vld=%b code=%0d cnt=%0d",
                        e.tag, viol_flags, first_vld, first_code, wr_count,
                        e.flags, e.vld, e.code, e.cnt);
            end
         end
      end
   end

   // Driver
   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      expect_state("R1 reset state", 9'h000, 1'b0, 4'd0);

      // R2: clean write, both strobes together
      mem_addr = 21'd1; tick(10);
      mem_data = 8'd5;  tick(5);
      mem_ce_n = 0; mem_we_n = 0; tick(8);
      mem_ce_n = 1; mem_we_n = 1; tick(5);
      mem_addr = 21'd2; tick(10);
      cnt_exp++;
      expect_state("R2 clean write", 9'h000, 1'b0, 4'd0);

      // R2: strobes low one at a time never form a window
      mem_ce_n = 0; tick(5); mem_ce_n = 1; tick(3);
      mem_we_n = 0; tick(5); mem_we_n = 1; tick(10);
      expect_state("R2 no overlap", 9'h000, 1'b0, 4'd0);

      // R3: short write strobe inside long chip select
      mem_ce_n = 0; tick(5);
      mem_we_n = 0; tick(4);
      mem_we_n = 1; tick(2);
      mem_ce_n = 1; tick(10);
      cnt_exp++;
      expect_state("R3 short pulse", 9'h010, 1'b1, 4'd4);
      clear_flags();

      // R4: short chip select inside long write strobe
      mem_we_n = 0; tick(3);
      mem_ce_n = 0; tick(6);
      mem_ce_n = 1; tick(1);
      mem_we_n = 1; tick(10);
      cnt_exp++;
      expect_state("R4 chip select to end", 9'h002, 1'b1, 4'd1);
      clear_flags();

      // R4 / R11: address changes on the opening sample
      mem_ce_n = 0; tick(3);
      mem_addr = 21'd3; mem_we_n = 0; tick(6);
      mem_we_n = 1; mem_ce_n = 1; tick(10);
      cnt_exp++;
      expect_state("R4 R11 address to end", 9'h004, 1'b1, 4'd2);
      clear_flags();

      // R5 / R9: data change inside window, then close
      mem_ce_n = 0; mem_we_n = 0; tick(6);
      mem_data = 8'd6; tick(1);
      mem_ce_n = 1; mem_we_n = 1; tick(10);
      cnt_exp++;
      expect_state("R5 R9 data in window", 9'h120, 1'b1, 4'd8);
      clear_flags();

      // R6: address changes too close together
      mem_addr = 21'd4; tick(3);
      mem_addr = 21'd5; tick(10);
      expect_state("R6 cycle time", 9'h001, 1'b1, 4'd0);
      clear_flags();

      // R7: address change on the write strobe rise, chip select still low
      mem_ce_n = 0; mem_we_n = 0; tick(8);
      mem_we_n = 1; mem_addr = 21'd6; tick(3);
      mem_ce_n = 1; tick(10);
      cnt_exp++;
      expect_state("R7 recovery fail", 9'h040, 1'b1, 4'd6);
      clear_flags();

      // R7: chip select alternative met, write strobe still low
      mem_ce_n = 0; mem_we_n = 0; tick(8);
      mem_ce_n = 1; tick(2);
      mem_addr = 21'd7; tick(2);
      mem_we_n = 1; tick(10);
      cnt_exp++;
      expect_state("R7 recovery via chip select", 9'h000, 1'b0, 4'd0);

      // R8: data changes as chip select rises, write strobe low
      mem_ce_n = 0; mem_we_n = 0; tick(8);
      mem_ce_n = 1; mem_data = 8'd7; tick(2);
      mem_we_n = 1; tick(10);
      cnt_exp++;
      expect_state("R8 hold fail", 9'h080, 1'b1, 4'd7);
      clear_flags();

      // R8: data changes as write strobe rises (zero hold allowed)
      mem_ce_n = 0; mem_we_n = 0; tick(8);
      mem_we_n = 1; mem_data = 8'd8; tick(2);
      mem_ce_n = 1; tick(10);
      cnt_exp++;
      expect_state("R8 hold via write strobe", 9'h000, 1'b0, 4'd0);

      // R10: first error is time order, not bit order
      mem_ce_n = 0; tick(5);
      mem_we_n = 0; tick(4);
      mem_we_n = 1; tick(2);
      mem_ce_n = 1; tick(10);
      cnt_exp++;
      mem_addr = 21'd8; tick(2);
      mem_addr = 21'd9; tick(10);
      expect_state("R10 sticky first", 9'h011, 1'b1, 4'd4);
      clear_flags();
      expect_state("R10 clear keeps count", 9'h000, 1'b0, 4'd0);

      tick(5);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   // Watchdog
   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule